// File: doc/BRIEF.md
# Selectable Infrared Carrier Generator

The block produces the modulated transmit signal for an infrared LED. A 3-bit select register picks one of six carrier waveforms derived from the system clock by division and duty, or picks no carrier at all. A 1-bit port data value gates the waveform. While the bit is set, the output carries the chosen carrier, or a plain high level when no carrier is selected. While the bit is clear, the output is low. A stop-mode input forces the output low at once.

Software writes the select code first and then sets the port bit to start a burst. Each burst starts with a complete high phase. A new select code written during a burst takes effect at the next period boundary, so no pulse is ever shortened.

A small state machine is at the centre of the block. Its states are:
- ST_IDLE: the port bit is clear.
- ST_MARK: the high phase of a carrier period.
- ST_SPACE: the low phase of a carrier period.
- ST_LEVEL: no-carrier transmission.
- ST_HALT: stop mode.

Its transitions are:
- Any state goes to ST_HALT while stop is asserted.
- Any state goes to ST_IDLE when the port bit is cleared.
- ST_IDLE or ST_HALT goes to ST_MARK or ST_LEVEL when a burst starts.
- ST_MARK goes to ST_SPACE after the last high clock.
- ST_SPACE goes to ST_MARK or ST_LEVEL at the end of the period.
- ST_LEVEL goes to ST_MARK on its next boundary when a carrier code is pending.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, tx_out is 0, the port bit is 0 and the select code is 000. A burst started without any select write therefore uses code 000.
- R2: Codes 000, 001 and 010 give a period of 12 clocks. The output is high for the first 6, 4 and 3 clocks of each period, respectively.
- R3: Codes 011 and 100 give a period of 8 clocks. The output is high for the first 4 and 2 clocks of each period, respectively.
- R4: Code 101 gives a period of 11 clocks. The output is high for the first 4 clocks of each period.
- R5: Codes 110 and 111 select no carrier. tx_out then equals the port bit.
- R6: While the port bit is 0, tx_out is 0. A select write made while the port bit is 0 does not change tx_out.
- R7: When the port bit goes from 0 to 1 on a clock edge, tx_out is high from that edge and the divider restarts at count 0. The first period is therefore complete.
- R8: While stop_mode is 1, tx_out is 0 in the same cycle. When stop_mode is released with the port bit still set, a new burst starts from count 0 at the next edge.
- R9: A select write during a carrier burst takes effect only at the end of the current period. The remaining part of that period keeps the old pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_en | input | 1 | Write strobe for the select register |
| sel_wr_data | input | 3 | New select code |
| port_wr_en | input | 1 | Write strobe for the port data bit |
| port_wr_data | input | 1 | New port data bit |
| stop_mode | input | 1 | Stop mode; forces the output inactive |
| tx_out | output | 1 | Modulated transmit signal, high means LED on |

## Verification
The assertions check the following on every cycle:
- Stop mode always leads to ST_HALT.
- A cleared port bit always leads to ST_IDLE.
- Every carrier burst starts in ST_MARK with the counter at zero.
- The divider count stays below the active period.
- The active select code cannot change during a high phase.

The bench scenarios are needed to show the rest:
- The exact high and low clock counts of each of the eight codes, checked against arithmetic over several periods.
- The boundary at which a code written mid-burst first applies.
- The restart after stop mode.
- The absence of any output change from a select write made while idle.

// File: rtl/ircar_pkg.sv
package ircar_pkg;

    localparam int SEL_W = 3;
    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MARK  = 3'd1,
        ST_SPACE = 3'd2,
        ST_LEVEL = 3'd3,
        ST_HALT  = 3'd4
    } ircar_state_e;

    typedef struct packed {
        logic             carrier;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] high;
    } ircar_wave_t;

    function automatic ircar_wave_t ircar_decode(input logic [SEL_W-1:0] code);
        ircar_wave_t w;
        w.carrier = 1'b1;
        unique case (code)
            3'b000: begin w.period = 4'd12; w.high = 4'd6; end
            3'b001: begin w.period = 4'd12; w.high = 4'd4; end
            3'b010: begin w.period = 4'd12; w.high = 4'd3; end
            3'b011: begin w.period = 4'd8;  w.high = 4'd4; end
            3'b100: begin w.period = 4'd8;  w.high = 4'd2; end
            3'b101: begin w.period = 4'd11; w.high = 4'd4; end
            default: begin w.carrier = 1'b0; w.period = 4'd1; w.high = 4'd1; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ircar_cfg_regs.sv
module ircar_cfg_regs
    import ircar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    input  logic             port_wr_en,
    input  logic             port_wr_data,
    output logic [SEL_W-1:0] sel_next,
    output logic             port_next
);

    logic [SEL_W-1:0] sel_q;
    logic             port_q;

    always_comb begin
        sel_next  = sel_wr_en  ? sel_wr_data  : sel_q;
        port_next = port_wr_en ? port_wr_data : port_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            port_q <= 1'b0;
        end else begin
            sel_q  <= sel_next;
            port_q <= port_next;
        end
    end

endmodule

// File: rtl/ircar_phase_ctr.sv
module ircar_phase_ctr
    import ircar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ircar_fsm.sv
module ircar_fsm
    import ircar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_next,
    input  logic             port_next,
    input  logic             stop_mode,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_inc,
    output logic             tx_out
);

    ircar_state_e     state, state_nxt;
    logic [SEL_W-1:0] act_sel;
    logic             load;
    ircar_wave_t      cur_w, new_w;
    logic [CNT_W-1:0] high_last, period_last;

    always_comb begin
        cur_w       = ircar_decode(act_sel);
        new_w       = ircar_decode(sel_next);
        high_last   = cur_w.high - 1'b1;
        period_last = cur_w.period - 1'b1;
    end

    always_comb begin
        state_nxt = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        load      = 1'b0;
        if (stop_mode) begin
            state_nxt = ST_HALT;
            cnt_clr   = 1'b1;
        end else if (!port_next) begin
            state_nxt = ST_IDLE;
            cnt_clr   = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE, ST_HALT, ST_LEVEL: begin
                    load      = 1'b1;
                    cnt_clr   = 1'b1;
                    state_nxt = new_w.carrier ? ST_MARK : ST_LEVEL;
                end
                ST_MARK: begin
                    cnt_inc = 1'b1;
                    if (cnt == high_last) state_nxt = ST_SPACE;
                end
                ST_SPACE: begin
                    if (cnt == period_last) begin
                        load      = 1'b1;
                        cnt_clr   = 1'b1;
                        state_nxt = new_w.carrier ? ST_MARK : ST_LEVEL;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    state_nxt = ST_IDLE;
                    cnt_clr   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            act_sel <= '0;
        end else begin
            state <= state_nxt;
            if (load) act_sel <= sel_next;
        end
    end

    always_comb begin
        tx_out = !stop_mode && ((state == ST_MARK) || (state == ST_LEVEL));
    end

    // R8: stop mode always leads to the halt state
    a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |=> (state == ST_HALT));

    // R6: a cleared port bit returns the machine to idle
    a_r6_idle_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_mode && !port_next) |=> (state == ST_IDLE));

    // R7: a carrier burst begins with a full high phase from count zero
    a_r7_full_first_high: assert property (@(posedge clk) disable iff (!rst_n)
        (((state == ST_IDLE) || (state == ST_HALT)) && !stop_mode && port_next
          && new_w.carrier) |=> ((state == ST_MARK) && (cnt == '0)));

    // R9: the active code cannot change inside a high phase
    a_r9_code_held_in_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MARK) |=> $stable(act_sel));

    // R2: the divider count stays inside the active period
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MARK) || (state == ST_SPACE)) |-> (cnt < cur_w.period));

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ircar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr_en,
    input  logic [SEL_W-1:0] sel_wr_data,
    input  logic             port_wr_en,
    input  logic             port_wr_data,
    input  logic             stop_mode,
    output logic             tx_out
);

    logic [SEL_W-1:0] sel_next;
    logic             port_next;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] cnt;

    ircar_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_wr_en    (sel_wr_en),
        .sel_wr_data  (sel_wr_data),
        .port_wr_en   (port_wr_en),
        .port_wr_data (port_wr_data),
        .sel_next     (sel_next),
        .port_next    (port_next)
    );

    ircar_phase_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    ircar_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_next  (sel_next),
        .port_next (port_next),
        .stop_mode (stop_mode),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .tx_out    (tx_out)
    );

    // R8: output is inactive in any cycle with stop asserted
    a_r8_stop_output_low: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> !tx_out);

endmodule

// File: tb/ir_carrier_gen_test.sv
`timescale 1ns/1ps
module ir_carrier_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr_en = 1'b0;
    logic [2:0] sel_wr_data = 3'b000;
    logic       port_wr_en = 1'b0;
    logic       port_wr_data = 1'b0;
    logic       stop_mode = 1'b0;
    logic       tx_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ir_carrier_gen uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_wr_en    (sel_wr_en),
        .sel_wr_data  (sel_wr_data),
        .port_wr_en   (port_wr_en),
        .port_wr_data (port_wr_data),
        .stop_mode    (stop_mode),
        .tx_out       (tx_out)
    );

    function automatic int per_of(input int code);
        case (code)
            0, 1, 2: return 12;
            3, 4:    return 8;
            5:       return 11;
            default: return 0;
        endcase
    endfunction

    function automatic int hi_of(input int code);
        case (code)
            0: return 6;
            1: return 4;
            2: return 3;
            3: return 4;
            4: return 2;
            5: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_wave(input int code, input int j);
        if (per_of(code) == 0) return 1'b1;
        return ((j % per_of(code)) < hi_of(code));
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            0, 1, 2: return "R2";
            3, 4:    return "R3";
            5:       return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit exp, input string tag);
        checks++;
        if (tx_out !== exp) begin
            errors++;
            $display("FAIL %s tx_out=%0b expected %0b at %0t", tag, tx_out, exp, $time);
        end
    endtask

    task automatic write_sel(input logic [2:0] code);
        sel_wr_en   = 1'b1;
        sel_wr_data = code;
        @(negedge clk);
        sel_wr_en   = 1'b0;
    endtask

    task automatic write_port(input logic v);
        port_wr_en   = 1'b1;
        port_wr_data = v;
        @(negedge clk);
        port_wr_en   = 1'b0;
    endtask

    task automatic run_wave(input int code, input int n, input string tag);
        for (int j = 0; j < n; j++) begin
            chk(exp_wave(code, j), tag);
            @(negedge clk);
        end
    endtask

    task automatic end_burst();
        write_port(1'b0);
        for (int j = 0; j < 3; j++) begin
            chk(1'b0, "R6");
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(1'b0, "R1");
        @(negedge clk);
        chk(1'b0, "R1");

        // R1 / R7: burst with no select write uses code 000 from a full high phase
        write_port(1'b1);
        run_wave(0, 36, "R1");
        end_burst();

        // R2 R3 R4 R5: sweep of every code over several periods
        for (int c = 0; c < 8; c++) begin
            write_sel(c[2:0]);
            chk(1'b0, "R6");
            write_port(1'b1);
            run_wave(c, 40, tag_of(c));
            end_burst();
        end

        // R6: select write while idle leaves the output low
        write_sel(3'b110);
        for (int j = 0; j < 4; j++) begin
            chk(1'b0, "R6");
            @(negedge clk);
        end
        write_sel(3'b011);
        chk(1'b0, "R6");

        // R7: second burst after idle restarts at count 0
        write_port(1'b1);
        run_wave(3, 5, "R7");
        end_burst();
        write_port(1'b1);
        run_wave(3, 16, "R7");

        // R8: stop forces the output low at once, release restarts the burst
        stop_mode = 1'b1;
        #1;
        chk(1'b0, "R8");
        @(negedge clk);
        for (int j = 0; j < 5; j++) begin
            chk(1'b0, "R8");
            @(negedge clk);
        end
        stop_mode = 1'b0;
        #1;
        chk(1'b0, "R8");
        @(negedge clk);
        run_wave(3, 16, "R8");
        end_burst();

        // R9: mid-burst code change waits for the period boundary
        write_sel(3'b000);
        write_port(1'b1);
        for (int j = 0; j < 3; j++) begin
            chk(exp_wave(0, j), "R9");
            if (j == 2) begin
                sel_wr_en   = 1'b1;
                sel_wr_data = 3'b011;
            end
            @(negedge clk);
        end
        sel_wr_en = 1'b0;
        for (int j = 3; j < 12; j++) begin
            chk(exp_wave(0, j), "R9");
            @(negedge clk);
        end
        run_wave(3, 24, "R9");

        // R9 / R5: change to no carrier mid-burst, then back to a carrier
        write_sel(3'b111);
        for (int j = 1; j < 8; j++) begin
            chk(exp_wave(3, j), "R9");
            @(negedge clk);
        end
        run_wave(7, 6, "R5");
        write_sel(3'b101);
        run_wave(5, 22, "R9");
        end_burst();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule